// File: doc/BRIEF.md
# Serial Chain Position ID Assigner

Stacked repeater chips are wired in a chain: each chip's serial input comes from the serial output of the chip above it. This block lets every chip in the chain learn a unique 3-bit position number without any software. It listens for a short serial frame on its input, checks the frame's parity, and adopts the ID carried in the frame as its own. It then keeps sending its own ID plus one (wrapping from 7 to 0) to the next chip downstream. The chip at the head of the chain has its input tied to the idle level, so it keeps ID 0 and announces ID 1.

A frame on either serial line is made of idle ones, then a start pattern of a 1 followed by a 0, then three ID bits least significant first, then one parity bit. The parity bit is 1 exactly when the ID holds an even number of ones. Every serial bit lasts one clock-enable tick (`tick`). The serial lines are plain level pins with no valid/ready handshake: bits are taken and sent at the tick rate, and no back-pressure exists in either direction. Two active-low control pins govern the ID. One of them freezes it against incoming frames. The other lets it fall back to 0 when no valid frame has arrived for a set number of ticks.

Top module: `rid_chain_unit`

## Requirements
- R1: While `rst_n` is low and directly after reset, `own_id` is 0 and `ser_out` is 1.
- R2: A frame on `ser_in` is recognised on ticks when a 1 is followed by a 0. The next three tick samples are the ID bits, least significant first, and the fourth is the parity bit. If the parity bit is 1 exactly when the ID has an even number of ones, and `ovr_en_n` is 1, `own_id` takes the received ID.
- R3: A frame whose parity bit does not match that rule is discarded, and `own_id` keeps its value.
- R4: While `ovr_en_n` is 0, frames on `ser_in` have no effect, and `own_id` is also shielded from the idle timeout.
- R5: `ser_out` repeatedly sends GAP_TICKS idle ones and then a frame. The frame is 1, 0, the ID (`own_id` + 1) mod 8 least significant bit first, and its parity bit, which is 1 exactly when that ID has an even number of ones. `ser_out` changes only in the cycle after a tick.
- R6: While `tmo_clr_n` is 0 and `ovr_en_n` is 1, `own_id` becomes 0 once TMO_TICKS ticks have passed with no valid frame.
- R7: Every valid frame restarts the idle timeout count, so valid frames spaced closer than TMO_TICKS ticks keep the ID.
- R8: While `tmo_clr_n` is 1, a long idle input leaves `own_id` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable; one serial bit time per tick |
| ser_in | input | 1 | Serial frame input from the chip above (idle 1) |
| ovr_en_n | input | 1 | 1 lets received frames set the ID; 0 freezes the ID |
| tmo_clr_n | input | 1 | 0 clears the ID to 0 after an idle timeout |
| ser_out | output | 1 | Serial frame output to the chip below (idle 1) |
| own_id | output | 3 | Current position ID of this chip |

## Verification
On every cycle, the assertions check several rules. The ID changes only when a frame is accepted or a timeout fires, and never while frames are blocked. An accepted frame loads exactly the received ID, and a frame with bad parity leaves the ID alone. A timeout hit with clearing enabled leaves the ID at 0, and the serial output moves only after a tick. Only the bench's scenarios can show the end-to-end behaviour: the frames actually emitted carry the incremented, wrapped ID with correct parity, the first chip of a chain behaves with an idle input, and spaced frames hold off the timeout while a long silence clears the ID only when clearing is enabled.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int RID_W = 3;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_DATA,
    RX_PAR
  } rx_state_t;
endpackage

// File: rtl/rid_rx.sv
module rid_rx #(
  parameter int ID_W = rid_pkg::RID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            din,
  output logic            done,
  output logic [ID_W-1:0] id,
  output logic            par
);
  import rid_pkg::*;
  localparam int CW = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(ID_W - 1);

  rx_state_t       st;
  logic            last_b;
  logic [CW-1:0]   cnt;
  logic [ID_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      last_b <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
      done   <= 1'b0;
      id     <= '0;
      par    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        last_b <= din;
        case (st)
          RX_IDLE: begin
            if (last_b && !din) begin
              st  <= RX_DATA;
              cnt <= '0;
            end
          end
          RX_DATA: begin
            sh[cnt] <= din;
            if (cnt == LAST) st <= RX_PAR;
            else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            done <= 1'b1;
            id   <= sh;
            par  <= din;
            st   <= RX_IDLE;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rid_tx.sv
module rid_tx #(
  parameter int ID_W      = rid_pkg::RID_W,
  parameter int GAP_TICKS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [ID_W-1:0] nxt_id,
  output logic            dout
);
  localparam int FB = ID_W + 3;
  localparam int PERIOD = GAP_TICKS + FB;
  localparam int PW = $clog2(PERIOD + 1);
  localparam logic [PW-1:0] GAP_P  = PW'(GAP_TICKS);
  localparam logic [PW-1:0] LOAD_P = PW'(GAP_TICKS - 1);
  localparam logic [PW-1:0] END_P  = PW'(PERIOD - 1);

  logic [PW-1:0] pos;
  logic [FB-1:0] fr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      fr   <= '1;
      dout <= 1'b1;
    end else if (tick) begin
      pos <= (pos == END_P) ? '0 : pos + 1'b1;
      if (pos < GAP_P) begin
        dout <= 1'b1;
        if (pos == LOAD_P) fr <= {~^nxt_id, nxt_id, 1'b0, 1'b1};
      end else begin
        dout <= fr[0];
        fr   <= {1'b1, fr[FB-1:1]};
      end
    end
  end
endmodule

// File: rtl/rid_tmo.sv
module rid_tmo #(
  parameter int TMO_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic hit
);
  localparam int CW = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TMO_TICKS - 1);

  logic [CW-1:0] cnt;

  assign hit = tick && !restart && (cnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (tick)       cnt <= (cnt == LIM) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rid_chain_unit.sv
module rid_chain_unit #(
  parameter int ID_W      = rid_pkg::RID_W,
  parameter int GAP_TICKS = 10,
  parameter int TMO_TICKS = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            ser_in,
  input  logic            ovr_en_n,
  input  logic            tmo_clr_n,
  output logic            ser_out,
  output logic [ID_W-1:0] own_id
);
  logic            frm_done;
  logic [ID_W-1:0] frm_id;
  logic            frm_par;
  logic            frm_good;
  logic            accept;
  logic            tmo_hit;

  assign frm_good = frm_done && (frm_par == ~^frm_id);
  assign accept   = frm_good && ovr_en_n;

  rid_rx #(.ID_W(ID_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(ser_in),
    .done(frm_done), .id(frm_id), .par(frm_par)
  );

  rid_tmo #(.TMO_TICKS(TMO_TICKS)) tmo_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(frm_good), .hit(tmo_hit)
  );

  rid_tx #(.ID_W(ID_W), .GAP_TICKS(GAP_TICKS)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .nxt_id(own_id + 1'b1), .dout(ser_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                   own_id <= '0;
    else if (accept)                              own_id <= frm_id;
    else if (tmo_hit && !tmo_clr_n && ovr_en_n)   own_id <= '0;
  end
endmodule

// File: rtl/rid_chain_chk.sv
module rid_chain_chk #(
  parameter int ID_W = rid_pkg::RID_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            ser_out,
  input logic            ovr_en_n,
  input logic            tmo_clr_n,
  input logic [ID_W-1:0] own_id,
  input logic            frm_done,
  input logic [ID_W-1:0] frm_id,
  input logic            frm_par,
  input logic            tmo_hit
);
  // R2
  good_frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && ovr_en_n && (frm_par == ~^frm_id)) |=> (own_id == $past(frm_id)));

  // R3
  bad_frame_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && (frm_par != ~^frm_id) && !tmo_hit) |=> $stable(own_id));

  // R4
  frozen_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en_n |=> $stable(own_id));

  // R5
  out_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $past(tick));

  // R6
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !tmo_clr_n && ovr_en_n) |=> (own_id == '0));

  // R8
  id_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(own_id) |-> $past(frm_done || (tmo_hit && !tmo_clr_n)));
endmodule

bind rid_chain_unit rid_chain_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ser_out(ser_out),
  .ovr_en_n(ovr_en_n), .tmo_clr_n(tmo_clr_n), .own_id(own_id),
  .frm_done(frm_done), .frm_id(frm_id), .frm_par(frm_par), .tmo_hit(tmo_hit)
);

// File: tb/rid_chain_unit_tb_top.sv
`timescale 1ns/1ps
module rid_chain_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ser_in = 1'b1;
  logic       ovr_en_n = 1'b1;
  logic       tmo_clr_n = 1'b1;
  logic       ser_out;
  logic [2:0] own_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;
  event tick_ev;

  typedef struct {
    logic [2:0] id;
    string      rq;
  } exp_t;
  exp_t q[$];

  rid_chain_unit #(.ID_W(3), .GAP_TICKS(10), .TMO_TICKS(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ser_in(ser_in),
    .ovr_en_n(ovr_en_n), .tmo_clr_n(tmo_clr_n),
    .ser_out(ser_out), .own_id(own_id)
  );

  always #4 clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      if (tc == 4) begin
        tc = 0;
        tick = 1'b1;
        -> tick_ev;
      end else begin
        tick = 1'b0;
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic send_frame(logic [2:0] id, logic par);
    repeat (3) begin @(tick_ev); ser_in = 1'b1; end
    @(tick_ev); ser_in = 1'b0;
    for (int i = 0; i < 3; i++) begin @(tick_ev); ser_in = id[i]; end
    @(tick_ev); ser_in = par;
    @(tick_ev); ser_in = 1'b1;
    @(tick_ev);
  endtask

  task automatic expect_id(logic [2:0] id, string rq);
    q.push_back('{id, rq});
    wait (q.size() == 0);
  endtask

  task automatic decode(output logic [2:0] id, output logic par);
    logic prev = 1'b1;
    logic cur;
    forever begin
      @(tick_ev);
      cur = ser_out;
      if (prev && !cur) break;
      prev = cur;
    end
    for (int i = 0; i < 3; i++) begin @(tick_ev); id[i] = ser_out; end
    @(tick_ev); par = ser_out;
  endtask

  // monitor: pops expected IDs and compares the port state and emitted frames
  initial begin
    exp_t       e;
    logic [2:0] got, nx;
    logic       gp;
    forever begin
      wait (q.size() > 0);
      e = q[0];
      chk(own_id == e.id, e.rq, "own_id", own_id, e.id);
      decode(got, gp);
      decode(got, gp);
      nx = e.id + 3'd1;
      chk(got == nx, e.rq, "ser_out frame id (R5)", got, nx);
      chk(gp == ~^nx, e.rq, "ser_out parity (R5)", gp, ~^nx);
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(own_id == 3'd0, "R1", "own_id in reset", own_id, 0);
    chk(ser_out == 1'b1, "R1", "ser_out in reset", ser_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(own_id == 3'd0, "R1", "own_id after reset", own_id, 0);
    chk(ser_out == 1'b1, "R1", "ser_out after reset", ser_out, 1);

    // head of chain: idle input keeps ID 0, sends 1
    expect_id(3'd0, "R5");
    // valid frame, ID 5 (two ones, parity 1)
    send_frame(3'd5, 1'b1);
    expect_id(3'd5, "R2");
    // ID 7 wraps to 0 downstream (three ones, parity 0)
    send_frame(3'd7, 1'b0);
    expect_id(3'd7, "R5");
    // ID 3 with wrong parity 0: discarded
    send_frame(3'd3, 1'b0);
    expect_id(3'd7, "R3");
    // frozen: valid ID 2 ignored
    ovr_en_n = 1'b0;
    send_frame(3'd2, 1'b0);
    expect_id(3'd7, "R4");
    ovr_en_n = 1'b1;
    // long idle with clearing disabled
    repeat (100) @(tick_ev);
    expect_id(3'd7, "R8");
    // clearing enabled: frames keep restarting the timer
    tmo_clr_n = 1'b0;
    send_frame(3'd4, 1'b0);
    expect_id(3'd4, "R2");
    for (int k = 0; k < 3; k++) begin
      send_frame(3'd6, 1'b1);
      repeat (40) @(tick_ev);
      chk(own_id == 3'd6, "R7", "own_id held by spaced frames", own_id, 6);
    end
    repeat (80) @(tick_ev);
    expect_id(3'd0, "R6");

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule